// File: doc/BRIEF.md
# Split-EOI interrupt state controller

This block is the CPU-side slice of an interrupt controller that serves a small group of interrupt lines. Each line is configured as level-sensitive or edge-triggered and has a priority. The line keeps its own four-state machine: Inactive, Pending, Active, and Active & Pending. The block picks the highest-priority pending line, signals it to the processor when it beats the current running priority, and keeps a stack of the priorities of the interrupts that have been acknowledged.

Software drives the block through three command strobes. Acknowledge takes the signalled interrupt. End-of-interrupt drops the running priority. Deactivate returns an interrupt to rest. A split control bit sets what end-of-interrupt does. When the bit is set, end-of-interrupt only drops the priority and deactivation is a separate command. When the bit is clear, end-of-interrupt drops the priority and deactivates in the same cycle. A line whose priority has been dropped but which has not been deactivated is never offered again. This holds even when its level input stays high, so a hypervisor can hold the physical source quiet until the guest has finished.

Top module: `sei_ctrl`

## Requirements
- R1: After reset, every line is Inactive, `run_prio` is 0xFF (idle), `hppi_id` and `ack_id` are 0xF (spurious), and `irq_out` and `err` are 0. In `line_state`, line i occupies bits [2i+1:2i], encoded as 00 Inactive, 01 Pending, 10 Active and 11 Active & Pending.
- R2: A level line that is Inactive becomes Pending one cycle after its input goes high, and returns to Inactive if the input falls while the line is still Pending. Acknowledging it while the input is high gives Active & Pending. If the input then falls, the line becomes Active.
- R3: An edge line becomes Pending on a rising edge of its input and stays Pending when the input falls. Acknowledge moves it to Active. A rising edge while it is Active gives Active & Pending.
- R4: With `split_mode`=1, an end-of-interrupt for an active line pops the priority stack and leaves every line state unchanged.
- R5: Deactivation of an active line makes it Inactive. A level line whose input is still high goes to Pending instead, and so does an edge line that was Active & Pending.
- R6: With `split_mode`=0, an end-of-interrupt pops the priority and deactivates the addressed line in the same cycle.
- R7: A line in Active or Active & Pending is never reported as `hppi_id`, whatever its input does.
- R8: `hppi_id` is the Pending line with the lowest priority value, with ties going to the lowest ID, or 0xF when no line is Pending. An acknowledge takes that line when `irq_out` is 1, pushes its priority, and shows its ID on `ack_id` from the next cycle on. An acknowledge while `irq_out` is 0 gives `ack_id`=0xF and changes nothing else.
- R9: The priority stack holds 4 entries. `run_prio` is the top entry, or 0xFF when the stack is empty. A pop restores the entry below. While the stack is full, `irq_out` stays 0.
- R10: `irq_out` is 1 only when the priority of `hppi_id` is strictly lower in value than `run_prio`.
- R11: An end-of-interrupt or deactivate addressed to a line that is not Active or Active & Pending changes no state and no priority, and sets `err`. Once set, `err` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_IRQ | Interrupt input lines |
| irq_level | input | N_IRQ | Per line: 1 for level-sensitive, 0 for edge-triggered |
| irq_prio | input | N_IRQ*PRIO_W | Per-line priority; line i occupies bits [8i+7:8i]; a lower value is more urgent |
| split_mode | input | 1 | 1: end-of-interrupt only drops the priority; 0: it also deactivates |
| ack_req | input | 1 | Acknowledge strobe |
| eoi_req | input | 1 | End-of-interrupt strobe |
| dir_req | input | 1 | Deactivate strobe |
| cmd_id | input | ID_W | Target line for end-of-interrupt and deactivate |
| ack_id | output | ID_W | ID returned by the last acknowledge |
| hppi_id | output | ID_W | Highest-priority Pending line, or all ones |
| irq_out | output | 1 | Interrupt request to the processor |
| run_prio | output | PRIO_W | Current running priority |
| line_state | output | 2*N_IRQ | Packed per-line state |
| err | output | 1 | Sticky flag for a command aimed at a line that is not active |

## Verification
The assertions assume that at most one command strobe is high in any cycle. They also assume that the per-line priorities and level/edge settings change only in cycles with no command, because the pushed priority is compared with the value seen at the acknowledge. The stimulus raises one strobe per step and changes priorities only between steps. Line inputs are the one free input, so they are moved with and without commands to reach every state transition.

// File: rtl/sei_pkg.sv
package sei_pkg;
  typedef enum logic [1:0] {
    ST_INACT   = 2'b00,
    ST_PEND    = 2'b01,
    ST_ACT     = 2'b10,
    ST_ACTPEND = 2'b11
  } irq_state_e;
endpackage

// File: rtl/sei_line.sv
module sei_line
  import sei_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq_in,
  input  logic       is_level,
  input  logic       ack_hit,
  input  logic       deact_hit,
  output irq_state_e state_q
);
  irq_state_e state_d;
  logic       in_q;
  logic       rise;
  logic       state_en;

  assign rise = irq_in & ~in_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_INACT:
        if (is_level ? irq_in : rise) state_d = ST_PEND;
      ST_PEND:
        if (ack_hit)
          state_d = (is_level ? irq_in : rise) ? ST_ACTPEND : ST_ACT;
        else if (is_level && !irq_in)
          state_d = ST_INACT;
      ST_ACT:
        if (deact_hit)
          state_d = (is_level ? irq_in : rise) ? ST_PEND : ST_INACT;
        else if (is_level ? irq_in : rise)
          state_d = ST_ACTPEND;
      ST_ACTPEND:
        if (deact_hit)
          state_d = (is_level && !irq_in) ? ST_INACT : ST_PEND;
        else if (is_level && !irq_in)
          state_d = ST_ACT;
      default: state_d = ST_INACT;
    endcase
  end

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_INACT;
      in_q    <= 1'b0;
    end else begin
      if (state_en) state_q <= state_d;
      in_q <= irq_in;
    end
  end
endmodule

// File: rtl/sei_stack.sv
module sei_stack #(
  parameter int DEPTH  = 4,
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [PRIO_W-1:0] push_prio,
  output logic [PRIO_W-1:0] top_prio,
  output logic              full,
  output logic              empty
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PRIO_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  top_idx;
  logic              do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty && !push;
  assign top_idx = cnt_q - CNT_W'(1);
  assign top_prio = empty ? {PRIO_W{1'b1}} : mem_q[top_idx[IDX_W-1:0]];

  always_comb begin
    cnt_d = cnt_q;
    if (do_push)     cnt_d = cnt_q + CNT_W'(1);
    else if (do_pop) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (do_push || do_pop) begin
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= '0;
      end else if (do_push && (cnt_q[IDX_W-1:0] == IDX_W'(g))) begin
        mem_q[g] <= push_prio;
      end
    end
  end
endmodule

// File: rtl/sei_select.sv
module sei_select #(
  parameter int N_IRQ  = 4,
  parameter int PRIO_W = 8,
  parameter int ID_W   = 4
) (
  input  logic [N_IRQ*PRIO_W-1:0] prio_flat,
  input  logic [N_IRQ-1:0]        pend,
  output logic                    found,
  output logic [ID_W-1:0]         best_id,
  output logic [PRIO_W-1:0]       best_prio
);
  always_comb begin
    found     = 1'b0;
    best_id   = {ID_W{1'b1}};
    best_prio = {PRIO_W{1'b1}};
    for (int i = 0; i < N_IRQ; i++) begin
      if (pend[i] && (!found || (prio_flat[i*PRIO_W +: PRIO_W] < best_prio))) begin
        found     = 1'b1;
        best_id   = ID_W'(i);
        best_prio = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/sei_ctrl.sv
module sei_ctrl
  import sei_pkg::*;
#(
  parameter int N_IRQ       = 4,
  parameter int PRIO_W      = 8,
  parameter int ID_W        = 4,
  parameter int STACK_DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_IRQ-1:0]        irq_in,
  input  logic [N_IRQ-1:0]        irq_level,
  input  logic [N_IRQ*PRIO_W-1:0] irq_prio,
  input  logic                    split_mode,
  input  logic                    ack_req,
  input  logic                    eoi_req,
  input  logic                    dir_req,
  input  logic [ID_W-1:0]         cmd_id,
  output logic [ID_W-1:0]         ack_id,
  output logic [ID_W-1:0]         hppi_id,
  output logic                    irq_out,
  output logic [PRIO_W-1:0]       run_prio,
  output logic [2*N_IRQ-1:0]      line_state,
  output logic                    err
);
  irq_state_e        st [N_IRQ];
  logic [N_IRQ-1:0]  pend, active, cmd_hot, best_hot, ack_vec, deact_vec;
  logic              found, full, empty;
  logic [ID_W-1:0]   best_id;
  logic [PRIO_W-1:0] best_prio;
  logic              do_ack, eoi_cmd, dir_cmd, tgt_active;
  logic              eoi_ok, dir_ok, bad_cmd, deact_go;
  logic [ID_W-1:0]   ack_id_d;
  logic              err_q;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_line
    assign pend[g]     = (st[g] == ST_PEND);
    assign active[g]   = (st[g] == ST_ACT) || (st[g] == ST_ACTPEND);
    assign cmd_hot[g]  = (cmd_id == ID_W'(g));
    assign best_hot[g] = (best_id == ID_W'(g));
    assign line_state[2*g +: 2] = st[g];

    sei_line i_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_in    (irq_in[g]),
      .is_level  (irq_level[g]),
      .ack_hit   (ack_vec[g]),
      .deact_hit (deact_vec[g]),
      .state_q   (st[g])
    );
  end

  sei_select #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .ID_W(ID_W)) i_select (
    .prio_flat (irq_prio),
    .pend      (pend),
    .found     (found),
    .best_id   (best_id),
    .best_prio (best_prio)
  );

  sei_stack #(.DEPTH(STACK_DEPTH), .PRIO_W(PRIO_W)) i_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (do_ack),
    .pop       (eoi_ok),
    .push_prio (best_prio),
    .top_prio  (run_prio),
    .full      (full),
    .empty     (empty)
  );

  // Command arbitration: acknowledge, then end-of-interrupt, then deactivate.
  assign irq_out    = found && (best_prio < run_prio) && !full;
  assign do_ack     = ack_req && irq_out;
  assign eoi_cmd    = eoi_req && !ack_req;
  assign dir_cmd    = dir_req && !ack_req && !eoi_req;
  assign tgt_active = |(active & cmd_hot);
  assign eoi_ok     = eoi_cmd && tgt_active;
  assign dir_ok     = dir_cmd && tgt_active;
  assign bad_cmd    = (eoi_cmd || dir_cmd) && !tgt_active;
  assign deact_go   = dir_ok || (eoi_ok && !split_mode);
  assign ack_vec    = best_hot & {N_IRQ{do_ack}};
  assign deact_vec  = cmd_hot & {N_IRQ{deact_go}};
  assign ack_id_d   = do_ack ? best_id : {ID_W{1'b1}};
  assign hppi_id    = best_id;
  assign err        = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_id <= {ID_W{1'b1}};
      err_q  <= 1'b0;
    end else begin
      if (ack_req) ack_id <= ack_id_d;
      if (bad_cmd) err_q  <= 1'b1;
    end
  end

  logic unused_empty;
  assign unused_empty = empty;
endmodule

// File: rtl/sei_ctrl_chk.sv
module sei_ctrl_chk #(
  parameter int N_IRQ  = 4,
  parameter int PRIO_W = 8,
  parameter int ID_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ack_req,
  input logic               eoi_req,
  input logic               dir_req,
  input logic               irq_out,
  input logic [PRIO_W-1:0]  hppi_prio,
  input logic [PRIO_W-1:0]  run_prio,
  input logic [ID_W-1:0]    ack_id,
  input logic [ID_W-1:0]    hppi_id,
  input logic [2*N_IRQ-1:0] line_state,
  input logic               err
);
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  a_r11_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(eoi_req || dir_req));

  a_r8_push_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && irq_out) |=> (run_prio == $past(hppi_prio)));

  a_r8_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !irq_out) |=> (ack_id == {ID_W{1'b1}}));

  for (genvar g = 0; g < N_IRQ; g++) begin : g_chk
    a_r7_active_hidden: assert property (@(posedge clk) disable iff (!rst_n)
      line_state[2*g+1] |-> (hppi_id != ID_W'(g)));
  end
endmodule

bind sei_ctrl sei_ctrl_chk #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .ID_W(ID_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ack_req    (ack_req),
  .eoi_req    (eoi_req),
  .dir_req    (dir_req),
  .irq_out    (irq_out),
  .hppi_prio  (best_prio),
  .run_prio   (run_prio),
  .ack_id     (ack_id),
  .hppi_id    (hppi_id),
  .line_state (line_state),
  .err        (err)
);

// File: tb/test_sei_ctrl.sv
module test_sei_ctrl;
  logic        clk, rst_n;
  logic [3:0]  irq_in, irq_level;
  logic [31:0] irq_prio;
  logic        split_mode, ack_req, eoi_req, dir_req;
  logic [3:0]  cmd_id;
  logic [3:0]  ack_id, hppi_id;
  logic        irq_out, err;
  logic [7:0]  run_prio;
  logic [7:0]  line_state;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  sei_ctrl i_sei_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_level(irq_level),
    .irq_prio(irq_prio), .split_mode(split_mode), .ack_req(ack_req),
    .eoi_req(eoi_req), .dir_req(dir_req), .cmd_id(cmd_id), .ack_id(ack_id),
    .hppi_id(hppi_id), .irq_out(irq_out), .run_prio(run_prio),
    .line_state(line_state), .err(err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // cmd: 0 none, 1 acknowledge, 2 end-of-interrupt, 3 deactivate
  typedef struct packed {
    logic [3:0] irq;
    logic [1:0] cmd;
    logic [3:0] id;
    logic       split;
    logic [7:0] st;
    logic [7:0] run;
    logic [3:0] hppi;
    logic       irqo;
    logic [3:0] ack;
    logic       err;
  } vec_t;

  // Lines 0,1 level; lines 2,3 edge. Priorities 0x40,0x20,0x60,0x20.
  localparam vec_t VEC [18] = '{
    '{4'b0000, 2'd0, 4'd0, 1'b1, 8'b00000000, 8'hFF, 4'hF, 1'b0, 4'hF, 1'b0}, // R1
    '{4'b0001, 2'd0, 4'd0, 1'b1, 8'b00000001, 8'hFF, 4'h0, 1'b1, 4'hF, 1'b0}, // R2
    '{4'b0001, 2'd1, 4'd0, 1'b1, 8'b00000011, 8'h40, 4'hF, 1'b0, 4'h0, 1'b0}, // R2 R8
    '{4'b0011, 2'd0, 4'd0, 1'b1, 8'b00000111, 8'h40, 4'h1, 1'b1, 4'h0, 1'b0}, // R10
    '{4'b0011, 2'd1, 4'd0, 1'b1, 8'b00001111, 8'h20, 4'hF, 1'b0, 4'h1, 1'b0}, // R8
    '{4'b0011, 2'd2, 4'd1, 1'b1, 8'b00001111, 8'h40, 4'hF, 1'b0, 4'h1, 1'b0}, // R4 R7
    '{4'b0001, 2'd0, 4'd0, 1'b1, 8'b00001011, 8'h40, 4'hF, 1'b0, 4'h1, 1'b0}, // R2
    '{4'b0001, 2'd3, 4'd1, 1'b1, 8'b00000011, 8'h40, 4'hF, 1'b0, 4'h1, 1'b0}, // R5
    '{4'b0001, 2'd2, 4'd0, 1'b0, 8'b00000001, 8'hFF, 4'h0, 1'b1, 4'h1, 1'b0}, // R6 R5
    '{4'b0000, 2'd0, 4'd0, 1'b1, 8'b00000000, 8'hFF, 4'hF, 1'b0, 4'h1, 1'b0}, // R2
    '{4'b0000, 2'd3, 4'd2, 1'b1, 8'b00000000, 8'hFF, 4'hF, 1'b0, 4'h1, 1'b1}, // R11
    '{4'b0100, 2'd0, 4'd0, 1'b1, 8'b00010000, 8'hFF, 4'h2, 1'b1, 4'h1, 1'b1}, // R3
    '{4'b0000, 2'd0, 4'd0, 1'b1, 8'b00010000, 8'hFF, 4'h2, 1'b1, 4'h1, 1'b1}, // R3
    '{4'b0000, 2'd1, 4'd0, 1'b1, 8'b00100000, 8'h60, 4'hF, 1'b0, 4'h2, 1'b1}, // R3
    '{4'b0100, 2'd0, 4'd0, 1'b1, 8'b00110000, 8'h60, 4'hF, 1'b0, 4'h2, 1'b1}, // R3 R7
    '{4'b0100, 2'd3, 4'd2, 1'b1, 8'b00010000, 8'h60, 4'h2, 1'b0, 4'h2, 1'b1}, // R5 R10
    '{4'b0100, 2'd2, 4'd2, 1'b1, 8'b00010000, 8'h60, 4'h2, 1'b0, 4'h2, 1'b1}, // R11
    '{4'b0100, 2'd1, 4'd0, 1'b1, 8'b00010000, 8'h60, 4'h2, 1'b0, 4'hF, 1'b1}  // R8
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a negedge: drive, let one posedge act, release strobes at the next negedge.
  task automatic step(input logic [3:0] irq, input logic [1:0] cmd,
                      input logic [3:0] id, input logic split);
    irq_in = irq; split_mode = split; cmd_id = id;
    ack_req = (cmd == 2'd1); eoi_req = (cmd == 2'd2); dir_req = (cmd == 2'd3);
    @(negedge clk);
    ack_req = 1'b0; eoi_req = 1'b0; dir_req = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    irq_in = '0; ack_req = 1'b0; eoi_req = 1'b0; dir_req = 1'b0; cmd_id = '0;
    split_mode = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    irq_level = 4'b0011;
    irq_prio  = {8'h20, 8'h60, 8'h20, 8'h40};
    do_reset();
    check("R1 state", line_state, 8'h00);
    check("R1 run_prio", run_prio, 8'hFF);
    check("R1 hppi_id", hppi_id, 4'hF);
    check("R1 ack_id", ack_id, 4'hF);
    check("R1 irq_out", irq_out, 1'b0);
    check("R1 err", err, 1'b0);

    for (int k = 0; k < 18; k++) begin
      step(VEC[k].irq, VEC[k].cmd, VEC[k].id, VEC[k].split);
      check($sformatf("vec %0d state", k), line_state, VEC[k].st);
      check($sformatf("vec %0d run_prio", k), run_prio, VEC[k].run);
      check($sformatf("vec %0d hppi_id", k), hppi_id, VEC[k].hppi);
      check($sformatf("vec %0d irq_out", k), irq_out, VEC[k].irqo);
      check($sformatf("vec %0d ack_id", k), ack_id, VEC[k].ack);
      check($sformatf("vec %0d err", k), err, VEC[k].err);
    end

    // R9: fill the 4-deep stack with nested acknowledges
    irq_prio = {8'h10, 8'h20, 8'h30, 8'h40};
    do_reset();
    step(4'b0001, 2'd0, 4'd0, 1'b1); step(4'b0001, 2'd1, 4'd0, 1'b1);
    step(4'b0011, 2'd0, 4'd0, 1'b1); step(4'b0011, 2'd1, 4'd0, 1'b1);
    step(4'b0111, 2'd0, 4'd0, 1'b1); step(4'b0111, 2'd1, 4'd0, 1'b1);
    step(4'b1111, 2'd0, 4'd0, 1'b1); step(4'b1111, 2'd1, 4'd0, 1'b1);
    check("R9 full run_prio", run_prio, 8'h10);
    check("R9 full states", line_state, 8'b10101111);
    step(4'b1111, 2'd3, 4'd2, 1'b1);
    check("R5 edge deactivate", line_state, 8'b10001111);
    irq_prio = {8'h10, 8'h05, 8'h30, 8'h40};
    step(4'b1011, 2'd0, 4'd0, 1'b1);
    step(4'b1111, 2'd0, 4'd0, 1'b1);
    check("R9 full hppi_id", hppi_id, 4'h2);
    check("R9 full blocks irq_out", irq_out, 1'b0);
    step(4'b1111, 2'd2, 4'd3, 1'b1);
    check("R9 pop restores", run_prio, 8'h20);
    check("R9 irq_out after pop", irq_out, 1'b1);
    check("R4 pop keeps states", line_state, 8'b10011111);

    // R8: equal priorities go to the lower ID
    irq_prio = {8'h20, 8'h60, 8'h20, 8'h40};
    do_reset();
    step(4'b1010, 2'd0, 4'd0, 1'b1);
    check("R8 tie hppi_id", hppi_id, 4'h1);
    step(4'b1010, 2'd1, 4'd0, 1'b1);
    check("R8 tie ack_id", ack_id, 4'h1);
    check("R8 tie next hppi", hppi_id, 4'h3);
    check("R10 equal prio no irq", irq_out, 1'b0);

    // R1: reset in mid-run clears everything
    do_reset();
    check("R1 re-reset state", line_state, 8'h00);
    check("R1 re-reset run_prio", run_prio, 8'hFF);
    check("R1 re-reset ack_id", ack_id, 4'hF);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule